// File: doc/BRIEF.md
# Channel Status Block Capture

This block watches a stream of decoded digital-audio subframes on the receive side and rebuilds the 192-bit channel status block carried one bit per frame. Only subframes of one chosen channel count, so each frame gives exactly one bit. A block-start marker on a subframe sets the bit position back to zero. The bits are gathered until the block is complete, then copied into a holding register that the host reads.

When a completed block differs from the value already held, the block raises an update flag. A host read strobe clears the flag. Capture runs whenever the receive path is enabled, whether or not any memory transfer has been started. Dropping the enable only pauses capture. The gathered state is cleared only by the hard reset or by the soft reset of the receive path.

Top module: `cs_status_capture`

## Requirements
- R1: After a hard reset, `cs_block` is all zeros and `cs_update` is 0.
- R2: A subframe is used only when `rx_en`, `sf_valid` are both 1 and `sf_chan` equals 0. Any other subframe, including one with `sf_blk_start` set, changes neither the outputs nor the partial block being gathered.
- R3: Bit n of `cs_block` (bit 0 is the LSB) is the `sf_cs_bit` of the n-th used subframe, counting the block-start subframe as n = 0.
- R4: A used subframe with `sf_blk_start` = 1 always restarts gathering at bit 0. Any partial block is dropped and `cs_block` keeps its value.
- R5: Once a block is complete, or after any reset, used subframes without `sf_blk_start` are ignored until a block-start subframe arrives.
- R6: On the clock edge that takes the 192nd bit of a block, `cs_block` loads the whole new block. The new value is visible one cycle after that bit is presented.
- R7: `cs_update` goes to 1 on the same edge as R6 when the new block differs from the value `cs_block` held before it.
- R8: A completed block equal to the held value leaves `cs_block` unchanged and does not set `cs_update`. An all-zero first block after reset therefore raises no flag.
- R9: `rd_clear` = 1 clears `cs_update` on the next edge. If a set event from R7 falls in the same cycle, the flag ends up 1.
- R10: `soft_rst` = 1 has the same effect as the hard reset: `cs_block` and `cs_update` go to 0, the partial block is dropped, and gathering waits for a block start.
- R11: Setting `rx_en` to 0 neither resets nor advances the capture. A partial block resumes at the next used subframe once `rx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Receive-path soft reset, synchronous, active high |
| rx_en | input | 1 | Receive path enabled |
| sf_valid | input | 1 | A subframe is presented this cycle |
| sf_chan | input | CHAN_W | Channel index of the subframe |
| sf_cs_bit | input | 1 | Channel status bit carried by the subframe |
| sf_blk_start | input | 1 | Subframe starts a new 192-frame block |
| rd_clear | input | 1 | Host read strobe for the update flag |
| cs_block | output | BLOCK_BITS | Last completed channel status block, LSB is the first bit |
| cs_update | output | 1 | A changed block has been captured since the last read |

## Verification
Every result is due exactly one clock after its cause. The final bit of a block, a read strobe and a soft reset are each taken on one rising edge, and `cs_block` and `cs_update` show the effect straight after that edge. The bench drives on falling edges and reads the outputs on the falling edge that follows the deciding rising edge, so each check sees the first cycle in which the new value is due. Checks for ignored input read the same outputs after the ignored stimulus ends and before the next block can complete. This shows that the value was not touched.

// File: rtl/cs_cap_pkg.sv
package cs_cap_pkg;

    // Assembler progress: waiting for a block start, or filling a block.
    typedef enum logic {
        ASM_HUNT = 1'b0,
        ASM_FILL = 1'b1
    } asm_state_e;

    // One qualified channel status contribution after subframe filtering.
    typedef struct packed {
        logic take;      // subframe is used for capture
        logic bit_val;   // channel status bit it carries
        logic start;     // subframe opens a new block
    } cs_bit_t;

    // Width of an index that addresses every bit of a block.
    function automatic int unsigned idx_width(input int unsigned nbits);
        return (nbits < 2) ? 1 : $clog2(nbits);
    endfunction

endpackage

// File: rtl/cs_sf_filter.sv
module cs_sf_filter
    import cs_cap_pkg::*;
#(
    parameter int unsigned CHAN_W    = 3,
    parameter int unsigned CAPT_CHAN = 0
) (
    input  logic              rx_en,
    input  logic              sf_valid,
    input  logic [CHAN_W-1:0] sf_chan,
    input  logic              sf_cs_bit,
    input  logic              sf_blk_start,
    output cs_bit_t           bit_out
);

    localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(CAPT_CHAN);

    logic chan_hit;

    always_comb begin
        chan_hit        = (sf_chan == CHAN_SEL);
        bit_out.take    = rx_en && sf_valid && chan_hit;
        bit_out.bit_val = sf_cs_bit;
        bit_out.start   = sf_blk_start;
    end

endmodule

// File: rtl/cs_bit_assembler.sv
module cs_bit_assembler
    import cs_cap_pkg::*;
#(
    parameter int unsigned BLOCK_BITS = 192
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  cs_bit_t               bit_in,
    output logic                  blk_done,
    output logic [BLOCK_BITS-1:0] blk_vec
);

    localparam int unsigned IDX_W = idx_width(BLOCK_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BITS - 1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

    asm_state_e            state_q, state_d;
    logic [IDX_W-1:0]      idx_q, idx_d;
    logic [BLOCK_BITS-1:0] buf_q;
    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic                  clr;

    assign clr = rst || soft_rst;

    // Next-state and write decision for the current contribution.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        wr_en    = 1'b0;
        wr_idx   = '0;
        blk_done = 1'b0;
        if (bit_in.take) begin
            if (bit_in.start) begin
                wr_en   = 1'b1;
                wr_idx  = '0;
                state_d = ASM_FILL;
                idx_d   = ONE_IDX;
            end else if (state_q == ASM_FILL) begin
                wr_en  = 1'b1;
                wr_idx = idx_q;
                if (idx_q == LAST_IDX) begin
                    blk_done = 1'b1;
                    state_d  = ASM_HUNT;
                    idx_d    = '0;
                end else begin
                    idx_d = idx_q + ONE_IDX;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ASM_HUNT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // One storage cell per block position, written in arrival order.
    for (genvar gi = 0; gi < BLOCK_BITS; gi++) begin : g_cell
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
        logic hit;
        assign hit = wr_en && (wr_idx == MY_IDX);

        always_ff @(posedge clk) begin
            if (clr) begin
                buf_q[gi] <= 1'b0;
            end else if (hit) begin
                buf_q[gi] <= bit_in.bit_val;
            end
        end

        // The assembled view already holds the bit being written now.
        assign blk_vec[gi] = hit ? bit_in.bit_val : buf_q[gi];
    end

    a_r2_idle_keeps_state: assert property (@(posedge clk) disable iff (clr)
        !bit_in.take |=> $stable(state_q) && $stable(idx_q) && $stable(buf_q));

    a_r4_start_resyncs: assert property (@(posedge clk) disable iff (clr)
        bit_in.take && bit_in.start |=> state_q == ASM_FILL && idx_q == ONE_IDX);

    a_r5_hunt_ignores: assert property (@(posedge clk) disable iff (clr)
        state_q == ASM_HUNT && bit_in.take && !bit_in.start
        |=> state_q == ASM_HUNT && $stable(buf_q));

    a_r6_done_leaves_fill: assert property (@(posedge clk) disable iff (clr)
        blk_done |=> state_q == ASM_HUNT && idx_q == '0);

endmodule

// File: rtl/cs_hold_flag.sv
module cs_hold_flag #(
    parameter int unsigned BLOCK_BITS = 192
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  blk_done,
    input  logic [BLOCK_BITS-1:0] blk_vec,
    input  logic                  rd_clear,
    output logic [BLOCK_BITS-1:0] held,
    output logic                  flag
);

    logic [BLOCK_BITS-1:0] held_q;
    logic                  flag_q;
    logic                  differs;
    logic                  set_evt;
    logic                  clr;

    assign clr     = rst || soft_rst;
    assign differs = (blk_vec != held_q);
    assign set_evt = blk_done && differs;

    always_ff @(posedge clk) begin
        if (clr) begin
            held_q <= '0;
        end else if (blk_done) begin
            held_q <= blk_vec;
        end
    end

    // A set event in the same cycle as a read strobe keeps the flag up.
    always_ff @(posedge clk) begin
        if (clr) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (rd_clear) begin
            flag_q <= 1'b0;
        end
    end

    assign held = held_q;
    assign flag = flag_q;

    a_r6_block_loaded: assert property (@(posedge clk) disable iff (clr)
        blk_done |=> held_q == $past(blk_vec));

    a_r7_flag_on_change: assert property (@(posedge clk) disable iff (clr)
        set_evt |=> flag_q);

    a_r8_same_block_stable: assert property (@(posedge clk) disable iff (clr)
        blk_done && !differs |=> $stable(held_q) && (flag_q == $past(flag_q) || !flag_q));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (clr)
        rd_clear && !set_evt |=> !flag_q);

endmodule

// File: rtl/cs_status_capture.sv
module cs_status_capture
    import cs_cap_pkg::*;
#(
    parameter int unsigned BLOCK_BITS = 192,
    parameter int unsigned CHAN_W     = 3,
    parameter int unsigned CAPT_CHAN  = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  rx_en,
    input  logic                  sf_valid,
    input  logic [CHAN_W-1:0]     sf_chan,
    input  logic                  sf_cs_bit,
    input  logic                  sf_blk_start,
    input  logic                  rd_clear,
    output logic [BLOCK_BITS-1:0] cs_block,
    output logic                  cs_update
);

    cs_bit_t               cs_bit;
    logic                  blk_done;
    logic [BLOCK_BITS-1:0] blk_vec;

    cs_sf_filter #(
        .CHAN_W    (CHAN_W),
        .CAPT_CHAN (CAPT_CHAN)
    ) u_filter (
        .rx_en        (rx_en),
        .sf_valid     (sf_valid),
        .sf_chan      (sf_chan),
        .sf_cs_bit    (sf_cs_bit),
        .sf_blk_start (sf_blk_start),
        .bit_out      (cs_bit)
    );

    cs_bit_assembler #(
        .BLOCK_BITS (BLOCK_BITS)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .bit_in   (cs_bit),
        .blk_done (blk_done),
        .blk_vec  (blk_vec)
    );

    cs_hold_flag #(
        .BLOCK_BITS (BLOCK_BITS)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .blk_done (blk_done),
        .blk_vec  (blk_vec),
        .rd_clear (rd_clear),
        .held     (cs_block),
        .flag     (cs_update)
    );

    a_r10_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !cs_update && cs_block == '0);

    a_r2_unused_no_change: assert property (@(posedge clk) disable iff (rst || soft_rst)
        !(rx_en && sf_valid) |=> $stable(cs_block));

endmodule

// File: tb/test_cs_status_capture.sv
module test_cs_status_capture;

    localparam int unsigned BB = 192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0;
    logic          rx_en = 1'b0;
    logic          sf_valid = 1'b0;
    logic [2:0]    sf_chan = '0;
    logic          sf_cs_bit = 1'b0;
    logic          sf_blk_start = 1'b0;
    logic          rd_clear = 1'b0;
    logic [BB-1:0] cs_block;
    logic          cs_update;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10ns clk = ~clk;

    cs_status_capture i_cs_status_capture (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .rx_en        (rx_en),
        .sf_valid     (sf_valid),
        .sf_chan      (sf_chan),
        .sf_cs_bit    (sf_cs_bit),
        .sf_blk_start (sf_blk_start),
        .rd_clear     (rd_clear),
        .cs_block     (cs_block),
        .cs_update    (cs_update)
    );

    function automatic logic [BB-1:0] pat(input int unsigned k);
        logic [BB-1:0] v;
        for (int w = 0; w < BB / 32; w++) begin
            int unsigned x;
            x = k * 32'd2654435761 + 32'(w) * 32'd40503 + 32'h1234_5678;
            x = x ^ (x >> 13);
            v[w*32 +: 32] = x;
        end
        return v;
    endfunction

    task automatic drive(input logic en, input logic v, input logic [2:0] ch,
                         input logic b, input logic st, input logic clr);
        @(negedge clk);
        rx_en = en; sf_valid = v; sf_chan = ch;
        sf_cs_bit = b; sf_blk_start = st; rd_clear = clr;
    endtask

    task automatic idle();
        drive(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
    endtask

    // Sends bits [first..last] of vec on channel 0; start marks bit 0 if asked.
    task automatic send_bits(input logic [BB-1:0] vec, input int first, input int last,
                             input bit with_start);
        for (int i = first; i <= last; i++)
            drive(1'b1, 1'b1, 3'd0, vec[i], with_start && (i == 0), 1'b0);
    endtask

    task automatic chk(input string req, input logic [BB-1:0] exp_b, input logic exp_f);
        n_tests++;
        if (cs_block !== exp_b || cs_update !== exp_f) begin
            n_fail++;
            $display("FAIL %s: block=%h flag=%b expected block=%h flag=%b",
                     req, cs_block, cs_update, exp_b, exp_f);
        end
    endtask

    initial begin
        logic [BB-1:0] a, b, c, d, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", '0, 1'b0);

        // R3 R6 R7: first nonzero block.
        a = pat(1);
        send_bits(a, 0, BB - 1, 1'b1); idle();
        chk("R3 R6 R7 first block", a, 1'b1);

        // R9: read clears.
        drive(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1); idle();
        chk("R9 read clear", a, 1'b0);

        // R8: identical block.
        send_bits(a, 0, BB - 1, 1'b1); idle();
        chk("R8 same block no flag", a, 1'b0);

        // R2 R11: interleave unused subframes and disabled cycles.
        b = pat(2);
        for (int i = 0; i < BB; i++) begin
            drive(1'b1, 1'b1, 3'd0, b[i], i == 0, 1'b0);
            if (i != BB - 1) begin
                drive(1'b1, 1'b1, 3'd1, ~b[i], 1'b1, 1'b0);
                drive(1'b0, 1'b1, 3'd0, ~b[i], 1'b1, 1'b0);
                drive(1'b1, 1'b0, 3'd0, ~b[i], 1'b1, 1'b0);
            end
        end
        idle();
        chk("R2 R11 unused subframes skipped", b, 1'b1);
        drive(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1); idle();

        // R4: partial block dropped, restart wins.
        c = pat(3);
        send_bits(c, 0, 99, 1'b1); idle();
        chk("R4 partial leaves held value", b, 1'b0);
        d = pat(4);
        send_bits(d, 0, BB - 1, 1'b1); idle();
        chk("R4 restart captures new block", d, 1'b1);

        // R5: bits after completion without a start are ignored.
        drive(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
        e = pat(5);
        send_bits(e, 0, BB - 1, 1'b0);
        send_bits(e, 0, 49, 1'b0); idle();
        chk("R5 hunting ignores bits", d, 1'b0);

        // R9: set and clear in the same cycle, set wins.
        c = pat(6);
        send_bits(c, 0, BB - 2, 1'b1);
        drive(1'b1, 1'b1, 3'd0, c[BB-1], 1'b0, 1'b1); idle();
        chk("R9 set wins over clear", c, 1'b1);

        // R10: soft reset drops everything including a partial block.
        send_bits(e, 0, 99, 1'b1);
        @(negedge clk); soft_rst = 1'b1; sf_valid = 1'b0;
        @(negedge clk); soft_rst = 1'b0;
        chk("R10 soft reset clears", '0, 1'b0);
        send_bits(e, 100, BB - 1, 1'b0); idle();
        chk("R10 partial dropped by soft reset", '0, 1'b0);

        // R8: all-zero block equal to reset value raises no flag.
        send_bits('0, 0, BB - 1, 1'b1); idle();
        chk("R8 zero block after reset", '0, 1'b0);

        // R3: sweep of every single-bit position.
        for (int p = 0; p < BB; p++) begin
            logic [BB-1:0] one;
            one = '0;
            one[p] = 1'b1;
            send_bits(one, 0, BB - 1, 1'b1); idle();
            chk($sformatf("R3 bit position %0d", p), one, 1'b1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule